// File: doc/BRIEF.md
# Data-Processing Operand Shifter

This block forms the second operand of a data-processing instruction. A 32-bit source value goes in with a 2-bit shift type, a shift amount and the current carry flag. The block returns the shifted operand and the shifter carry-out, which the ALU behind it uses for logical instructions that update flags. The unit is purely combinational.

The amount comes in one of two forms, chosen by a select input. The immediate form carries a 5-bit amount in which zero has special meanings. Zero with a left shift means no shift. Zero with either right shift means a shift by 32. Zero with a rotate means a one-bit rotate through the carry flag. The register form takes the amount from the low 8 bits of a register value and handles amounts of 0, exactly 32 and more than 32 with their own carry rules.

A single barrel shifter covers counts 1 to 31 for all four types. A small decoder looks at the amount and picks either the barrel result or one of the fixed special-case results.

Top module: `opshift_unit`

## Requirements
- R1: The shift type encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For an effective count n from 1 to 31, the result is the source shifted or rotated by n. Logical shifts fill with zeros and the arithmetic right shift fills with copies of bit 31.
- R2: When `use_reg_amt` is 1, only bits [7:0] of `reg_amt` set the amount and its upper bits have no effect. When `use_reg_amt` is 0, `reg_amt` has no effect and only `imm_amt` sets the amount.
- R3: In register form, an amount of 0 returns the source unchanged with carry-out equal to `carry_in`, for every shift type.
- R4: For a count n from 1 to 31, the carry-out of a logical left shift is source bit (32 - n). For logical right and arithmetic right it is source bit (n - 1).
- R5: In register form, a logical left shift by exactly 32 gives result 0 with carry-out equal to source bit 0. A logical right shift by exactly 32 gives result 0 with carry-out equal to source bit 31.
- R6: In register form, a logical left or logical right shift by more than 32 gives result 0 and carry-out 0.
- R7: An arithmetic right shift by 32 or more in register form, and one with immediate amount 0, gives 32 copies of source bit 31 with carry-out equal to source bit 31.
- R8: In register form, a rotate uses only amount bits [3:0] as its count. When the 8-bit amount is nonzero but those 4 bits are 0, the result is the source unchanged and carry-out equals source bit 31.
- R9: A rotate by a nonzero count n (immediate bits [4:0], or register bits [3:0]) gives carry-out equal to source bit (n - 1), which is also bit 31 of the result.
- R10: In immediate form, a logical left shift with amount 0 returns the source unchanged with carry-out equal to `carry_in`.
- R11: In immediate form, a logical right shift with amount 0 acts as a shift by 32: result 0, carry-out equal to source bit 31.
- R12: In immediate form, a rotate with amount 0 returns {`carry_in`, source[31:1]} with carry-out equal to source bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Value to be shifted |
| shift_kind | input | 2 | Shift type, encoded as in R1 |
| use_reg_amt | input | 1 | 1 selects the register amount, 0 selects the immediate amount |
| imm_amt | input | 5 | Immediate shift amount |
| reg_amt | input | 32 | Register value holding the amount in its low 8 bits |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench aims at the amount boundaries: 0, 1, 31, 32, 33 and 255 in register form, and amount 0 for each type in immediate form. A design that passes the barrel result through at these points would return the source shifted by 0 where zero is required, or take the carry from the wrong bit. Register amounts whose upper bits are set, and rotate amounts that are multiples of 16, catch a decoder that reads too many amount bits. That fault would show up as a changed result or a carry taken from bit n-1 instead of bit 31. Rotates by 0 in immediate form check that the carry flag goes into bit 31 and that bit 0 comes out as the carry. A design that swapped the two would fail whenever `carry_in` and source bit 0 differ.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  // Shift type code carried on the shift_kind port
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  // Which result source the output mux forwards
  typedef enum logic [2:0] {
    OS_PASS   = 3'd0,  // unchanged source, carry flag through
    OS_BARREL = 3'd1,  // barrel result, count 1..DATA_W-1
    OS_FULL   = 3'd2,  // shift by exactly DATA_W
    OS_BEYOND = 3'd3,  // shift by more than DATA_W
    OS_RRX    = 3'd4,  // one-bit rotate through carry
    OS_WRAP   = 3'd5   // rotate by a whole multiple of the rotate span
  } out_sel_e;

endpackage

// File: rtl/opshift_amt_decode.sv
module opshift_amt_decode
  import opshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  parameter int ROT_CNT_W = 4,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  shift_kind_e          kind,
  input  logic                 use_reg,
  input  logic [CNT_W-1:0]     imm_amt,
  input  logic [REG_AMT_W-1:0] reg_amt,
  output out_sel_e             sel,
  output logic [CNT_W-1:0]     cnt
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  logic                 reg_zero;
  logic                 reg_full;
  logic                 reg_over;
  logic [ROT_CNT_W-1:0] rot_cnt;

  assign reg_zero = (reg_amt == '0);
  assign reg_full = (reg_amt == FULL_AMT);
  assign reg_over = (reg_amt > FULL_AMT);
  assign rot_cnt  = reg_amt[ROT_CNT_W-1:0];

  always_comb begin
    sel = OS_BARREL;
    cnt = '0;
    if (use_reg) begin
      if (reg_zero) begin
        sel = OS_PASS;
      end else if (kind == SK_ROR) begin
        if (rot_cnt == '0) sel = OS_WRAP;
        else               cnt = CNT_W'(rot_cnt);
      end else if (reg_full) begin
        sel = OS_FULL;
      end else if (reg_over) begin
        sel = OS_BEYOND;
      end else begin
        cnt = reg_amt[CNT_W-1:0];
      end
    end else if (imm_amt == '0) begin
      case (kind)
        SK_LSL:  sel = OS_PASS;
        SK_ROR:  sel = OS_RRX;
        default: sel = OS_FULL;
      endcase
    end else begin
      cnt = imm_amt;
    end
  end

endmodule

// File: rtl/opshift_barrel.sv
module opshift_barrel
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] val,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res,
  output logic              cbit
);

  // One stage: move by a fixed distance d according to the type
  function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] v,
                                             input shift_kind_e kd,
                                             input int d);
    case (kd)
      SK_LSL:  return v << d;
      SK_LSR:  return v >> d;
      SK_ASR:  return DATA_W'($signed(v) >>> d);
      default: return (v >> d) | (v << (DATA_W - d));
    endcase
  endfunction

  // Last bit moved out: index DATA_W-n for left, n-1 otherwise
  function automatic logic tap(input logic [DATA_W-1:0] v,
                               input shift_kind_e kd,
                               input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] idx;
    if (n == '0) return 1'b0;
    idx = (kd == SK_LSL) ? (CNT_W'(0) - n) : (n - 1'b1);
    return v[idx];
  endfunction

  logic [DATA_W-1:0] stg [CNT_W+1];

  assign stg[0] = val;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    assign stg[k+1] = cnt[k] ? step(stg[k], kind, 1 << k) : stg[k];
  end

  assign res  = stg[CNT_W];
  assign cbit = tap(val, kind, cnt);

endmodule

// File: rtl/opshift_outmux.sv
module opshift_outmux
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  out_sel_e          sel,
  input  shift_kind_e       kind,
  input  logic [DATA_W-1:0] src,
  input  logic              cin,
  input  logic [DATA_W-1:0] bar_res,
  input  logic              bar_c,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  logic msb;
  assign msb = src[DATA_W-1];

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (sel)
      OS_PASS: begin
        res  = src;
        cout = cin;
      end
      OS_BARREL: begin
        res  = bar_res;
        cout = bar_c;
      end
      OS_FULL: begin
        if (kind == SK_ASR) begin
          res  = {DATA_W{msb}};
          cout = msb;
        end else begin
          cout = (kind == SK_LSL) ? src[0] : msb;
        end
      end
      OS_BEYOND: begin
        if (kind == SK_ASR) begin
          res  = {DATA_W{msb}};
          cout = msb;
        end
      end
      OS_RRX: begin
        res  = {cin, src[DATA_W-1:1]};
        cout = src[0];
      end
      OS_WRAP: begin
        res  = src;
        cout = msb;
      end
      default: begin
        res  = '0;
        cout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  parameter int ROT_CNT_W = 4,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [1:0]        shift_kind,
  input  logic              use_reg_amt,
  input  logic [CNT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] op_out,
  output logic              carry_out
);

  shift_kind_e       kind;
  out_sel_e          out_sel;
  logic [CNT_W-1:0]  bar_cnt;
  logic [DATA_W-1:0] bar_res;
  logic              bar_c;
  logic              unused_amt_hi;

  assign kind          = shift_kind_e'(shift_kind);
  assign unused_amt_hi = ^reg_amt[DATA_W-1:REG_AMT_W];

  opshift_amt_decode #(
    .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W), .ROT_CNT_W(ROT_CNT_W)
  ) u_dec (
    .kind    (kind),
    .use_reg (use_reg_amt),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt[REG_AMT_W-1:0]),
    .sel     (out_sel),
    .cnt     (bar_cnt)
  );

  opshift_barrel #(.DATA_W(DATA_W)) u_bar (
    .kind (kind),
    .val  (src_val),
    .cnt  (bar_cnt),
    .res  (bar_res),
    .cbit (bar_c)
  );

  opshift_outmux #(.DATA_W(DATA_W)) u_mux (
    .sel     (out_sel),
    .kind    (kind),
    .src     (src_val),
    .cin     (carry_in),
    .bar_res (bar_res),
    .bar_c   (bar_c),
    .res     (op_out),
    .cout    (carry_out)
  );

endmodule

// File: rtl/opshift_unit_checks.sv
module opshift_unit_checks
  import opshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] src_val,
  input logic [1:0]        shift_kind,
  input logic              use_reg_amt,
  input logic [CNT_W-1:0]  imm_amt,
  input logic [DATA_W-1:0] reg_amt,
  input logic              carry_in,
  input logic [DATA_W-1:0] op_out,
  input logic              carry_out,
  input out_sel_e          out_sel
);

  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  logic [REG_AMT_W-1:0] ramt;
  logic                 msb;
  assign ramt = reg_amt[REG_AMT_W-1:0];
  assign msb  = src_val[DATA_W-1];

  always_comb begin
    // R3: register amount zero passes value and carry flag
    if (use_reg_amt && ramt == '0)
      a_r3_reg_zero_pass: assert (op_out == src_val && carry_out == carry_in);

    // R6: logical shifts beyond the width clear result and carry
    if (use_reg_amt && ramt > FULL_AMT && shift_kind[1] == 1'b0)
      a_r6_beyond_clear: assert (op_out == '0 && carry_out == 1'b0);

    // R7: arithmetic right at or past the width fills with the sign
    if (shift_kind == 2'd2 && (use_reg_amt ? (ramt >= FULL_AMT) : (imm_amt == '0)))
      a_r7_asr_sign_fill: assert (op_out == {DATA_W{msb}} && carry_out == msb);

    // R8: nonzero register rotate amount with zero count keeps the value
    if (use_reg_amt && shift_kind == 2'd3 && ramt != '0 && ramt[3:0] == 4'd0)
      a_r8_rot_wrap: assert (op_out == src_val && carry_out == msb);

    // R9: a real rotate hands out the new bit 31 as carry
    if (shift_kind == 2'd3 && out_sel == OS_BARREL)
      a_r9_rot_carry_msb: assert (carry_out == op_out[DATA_W-1]);

    // R12: immediate rotate by zero goes through carry
    if (!use_reg_amt && shift_kind == 2'd3 && imm_amt == '0)
      a_r12_rrx: assert (op_out == {carry_in, src_val[DATA_W-1:1]} && carry_out == src_val[0]);

    // R10: decoder pass selection leaves the value untouched
    if (out_sel == OS_PASS)
      a_r10_pass_value: assert (op_out == src_val && carry_out == carry_in);
  end

endmodule

bind opshift_unit opshift_unit_checks #(
  .DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)
) u_checks (
  .src_val     (src_val),
  .shift_kind  (shift_kind),
  .use_reg_amt (use_reg_amt),
  .imm_amt     (imm_amt),
  .reg_amt     (reg_amt),
  .carry_in    (carry_in),
  .op_out      (op_out),
  .carry_out   (carry_out),
  .out_sel     (out_sel)
);

// File: tb/opshift_unit_bench.sv
module opshift_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        use_reg_amt = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] reg_amt = '0;
  logic        carry_in = 1'b0;
  logic [31:0] op_out;
  logic        carry_out;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  opshift_unit u_opshift_unit (
    .src_val     (src_val),
    .shift_kind  (shift_kind),
    .use_reg_amt (use_reg_amt),
    .imm_amt     (imm_amt),
    .reg_amt     (reg_amt),
    .carry_in    (carry_in),
    .op_out      (op_out),
    .carry_out   (carry_out)
  );

  // rotate right by one, repeated r times
  function automatic logic [31:0] rot_n(input logic [31:0] v, input int r);
    logic [31:0] t = v;
    for (int i = 0; i < r; i++) t = {t[0], t[31:1]};
    return t;
  endfunction

  // expected {carry, result} from the requirements
  function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] k,
                                            input logic ur, input logic [4:0] ai,
                                            input logic [31:0] ar, input logic c);
    int n;
    logic [63:0] w;
    logic [31:0] r;
    n = ur ? int'(ar[7:0]) : int'(ai);
    if (ur && n == 0) return {c, v};
    if (!ur && n == 0) begin
      if (k == 2'd0) return {c, v};
      if (k == 2'd3) return {v[0], c, v[31:1]};
      n = 32;
    end
    case (k)
      2'd0: begin
        if (n > 32) return 33'd0;
        w = {32'd0, v} << n;
        return {w[32], w[31:0]};
      end
      2'd1: begin
        if (n > 32) return 33'd0;
        w = {v, 32'd0} >> n;
        return {w[31], w[63:32]};
      end
      2'd2: begin
        if (n >= 32) return {v[31], {32{v[31]}}};
        w = 64'($signed({v, 32'd0}) >>> n);
        return {w[31], w[63:32]};
      end
      default: begin
        if (ur) begin
          n = n % 16;
          if (n == 0) return {v[31], v};
        end
        r = rot_n(v, n);
        return {r[31], r};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic ur,
                                   input logic [4:0] ai, input logic [31:0] ar);
    int n;
    if (ur) begin
      n = int'(ar[7:0]);
      if (n == 0) return "R3";
      if (k == 2'd3) return (n % 16 == 0) ? "R8" : "R9";
      if (n == 32) return (k == 2'd2) ? "R7" : "R5";
      if (n > 32)  return (k == 2'd2) ? "R7" : "R6";
      return "R4";
    end
    if (ai == 5'd0) begin
      case (k)
        2'd0: return "R10";
        2'd1: return "R11";
        2'd2: return "R7";
        default: return "R12";
      endcase
    end
    return (k == 2'd3) ? "R9" : "R4";
  endfunction

  task automatic run_case(input string tag, input logic [31:0] v, input logic [1:0] k,
                          input logic ur, input logic [4:0] ai, input logic [31:0] ar,
                          input logic c);
    logic [32:0] exp;
    @(negedge clk);
    src_val = v; shift_kind = k; use_reg_amt = ur; imm_amt = ai; reg_amt = ar; carry_in = c;
    #1;
    exp = ref_shift(v, k, ur, ai, ar, c);
    n_cmp++;
    if ({carry_out, op_out} !== exp) begin
      n_bad++;
      $display("FAIL %s: src=%h kind=%0d reg=%0b imm=%0d ramt=%h cin=%0b got res=%h c=%0b exp res=%h c=%0b",
               tag, v, k, ur, ai, ar, c, op_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1: watchdog expired, got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd1207);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-state inputs: immediate left shift by 0 of zero
    run_case("R10", 32'h0, 2'd0, 1'b0, 5'd0, 32'h0, 1'b0);

    // R1 / R4: plain shifts and rotates, immediate and register
    run_case("R1", 32'h8000_0001, 2'd0, 1'b0, 5'd1,  32'h0, 1'b0);
    run_case("R1", 32'h8000_0001, 2'd1, 1'b0, 5'd31, 32'h0, 1'b0);
    run_case("R1", 32'h8765_4321, 2'd2, 1'b1, 5'd0,  32'd4, 1'b1);
    run_case("R1", 32'h1234_5678, 2'd3, 1'b0, 5'd8,  32'h0, 1'b0);
    run_case("R4", 32'h4000_0000, 2'd0, 1'b1, 5'd0,  32'd2, 1'b0);
    run_case("R4", 32'h0000_0010, 2'd1, 1'b1, 5'd0,  32'd5, 1'b0);
    // R2: upper amount bits ignored, register amount ignored in immediate form
    run_case("R2", 32'hF0F0_1234, 2'd1, 1'b1, 5'd9,  32'hFFFF_FF04, 1'b0);
    run_case("R2", 32'hF0F0_1234, 2'd0, 1'b0, 5'd3,  32'h0000_0021, 1'b1);
    // R3
    for (int k = 0; k < 4; k++) begin
      run_case("R3", 32'hA5A5_5A5A, 2'(k), 1'b1, 5'd7, 32'hABCD_0000, 1'b1);
    end
    // R5
    run_case("R5", 32'h0000_0001, 2'd0, 1'b1, 5'd0, 32'd32, 1'b0);
    run_case("R5", 32'h8000_0000, 2'd1, 1'b1, 5'd0, 32'd32, 1'b0);
    // R6
    run_case("R6", 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 32'd33,  1'b1);
    run_case("R6", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 32'd255, 1'b1);
    // R7
    run_case("R7", 32'h8000_0000, 2'd2, 1'b1, 5'd0, 32'd32,  1'b0);
    run_case("R7", 32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 32'd200, 1'b1);
    run_case("R7", 32'h9000_0000, 2'd2, 1'b0, 5'd0, 32'h0,   1'b0);
    // R8
    run_case("R8", 32'h8000_0001, 2'd3, 1'b1, 5'd0, 32'd16,  1'b0);
    run_case("R8", 32'h0000_0001, 2'd3, 1'b1, 5'd0, 32'd240, 1'b1);
    // R9
    run_case("R9", 32'h0000_0002, 2'd3, 1'b1, 5'd0, 32'd18, 1'b0);
    run_case("R9", 32'h0000_0001, 2'd3, 1'b0, 5'd31, 32'h0, 1'b0);
    // R10, R11, R12
    run_case("R10", 32'hDEAD_BEEF, 2'd0, 1'b0, 5'd0, 32'hFF, 1'b1);
    run_case("R11", 32'h8000_0000, 2'd1, 1'b0, 5'd0, 32'h0,  1'b0);
    run_case("R12", 32'h0000_0001, 2'd3, 1'b0, 5'd0, 32'h0,  1'b0);
    run_case("R12", 32'h0000_0002, 2'd3, 1'b0, 5'd0, 32'h0,  1'b1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] v, ar, hi;
      logic [1:0]  k;
      logic        ur, c;
      logic [4:0]  ai;
      v  = $urandom;
      hi = $urandom;
      k  = 2'($urandom);
      ur = 1'($urandom);
      c  = 1'($urandom);
      ai = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      case ($urandom % 4)
        0: ar = hi;
        1: ar = {hi[31:8], 8'($urandom % 41)};
        2: ar = {hi[31:8], 8'd32};
        default: ar = {hi[31:8], 8'(($urandom % 16) * 16)};
      endcase
      run_case(tag_of(k, ur, ai, ar), v, k, ur, ai, ar, c);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule